// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside the receive path of an Ethernet MAC. It watches the first six bytes of each frame, the destination address, and decides whether the frame is kept. Bytes arrive one per `byte_vld_i` cycle. `sof_i` is raised together with the first address byte. Idle cycles may fall between address bytes.

The decision has four sources. Promiscuous mode keeps every frame. The all-ones broadcast address is kept unless broadcast rejection is on. Any other group address (a multicast address) is looked up in a 64-entry hash table. The table index is taken from the top six bits of a CRC-32 computed over the destination bytes while they stream in. An individual (unicast) address must equal the programmed station address exactly.

The verdict comes out as a one-cycle `dec_vld_o` pulse with `accept_o` in the cycle after the sixth address byte is taken. Any further bytes of the frame are ignored until the next `sof_i`.

Top module: `rx_addr_filter`

## Requirements
- R1: During reset and after it, `dec_vld_o` and `accept_o` are low. Bytes received without a preceding `sof_i` produce no decision.
- R2: `sof_i` with `byte_vld_i` marks address byte 0. `dec_vld_o` is high for exactly one cycle, the cycle after the clock edge that takes address byte 5. `accept_o` is low whenever `dec_vld_o` is low.
- R3: A destination whose byte 0 has bit 0 clear is accepted when it equals the station address. Byte 0 is `station_hi_i[15:8]` and byte 1 is `station_hi_i[7:0]`. Bytes 2 to 5 are `station_lo_i[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R4: A destination with bit 0 of byte 0 clear that differs from the station address in any byte is rejected (promiscuous off).
- R5: The all-ones destination is accepted when `bcast_rej_i` is 0.
- R6: The all-ones destination is rejected when `bcast_rej_i` is 1 and `promisc_i` is 0.
- R7: With `promisc_i` at 1, every destination is accepted, including broadcast while `bcast_rej_i` is 1.
- R8: A destination that is not all-ones and has bit 0 of byte 0 set is accepted exactly when the selected hash bit is 1. The CRC uses polynomial 0x04C11DB7, starts at all ones, takes each byte LSB first and is not inverted at the end. Its bits 31:26 form a 6-bit index. Index bit 5 selects `hash1_i` (1) or `hash0_i` (0), and index bits 4:0 select the bit within that word.
- R9: With both hash words all ones, every such multicast destination is accepted. With both at zero, every one is rejected.
- R10: Bytes after the sixth are ignored until the next `sof_i`. A `sof_i` that arrives part-way through an address restarts the capture at byte 0.
- R11: Idle cycles between address bytes do not change the decision; only its timing moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | First address byte of a frame |
| byte_vld_i | input | 1 | `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte |
| station_lo_i | input | 32 | Station address bytes 2..5 |
| station_hi_i | input | 16 | Station address bytes 0..1 |
| hash0_i | input | 32 | Hash table word, index 0..31 |
| hash1_i | input | 32 | Hash table word, index 32..63 |
| promisc_i | input | 1 | Accept every frame |
| bcast_rej_i | input | 1 | Discard broadcast frames |
| dec_vld_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted (valid with strobe) |

## Verification
The embedded assertions check the following on every cycle:
- the decision strobe lasts a single cycle;
- the strobe only follows a taken byte;
- the byte counter never runs past the address length;
- promiscuous mode always accepts;
- a rejected broadcast never passes;
- an exact unicast match always passes.

The hash path can only be shown by the bench scenarios. These search for multicast addresses whose CRC index lands in each hash word, then set or clear that single bit. The bench scenarios also cover:
- the station-register byte mapping;
- mid-address restarts;
- ignoring trailing bytes;
- gapped byte streams.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int unsigned CRC_W = 32;
   localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
   localparam logic [CRC_W-1:0] CRC_SEED = '1;
endpackage

// File: rtl/rxf_crc_step.sv
module rxf_crc_step #(
   parameter int unsigned CRC_W = 32,
   parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
   input  logic [CRC_W-1:0] crc_i,
   input  logic [7:0]       data_i,
   output logic [CRC_W-1:0] crc_o
);
   logic [8:0][CRC_W-1:0] st;
   assign st[0] = crc_i;
   generate
      for (genvar k = 0; k < 8; k++) begin : g_bit
         logic fb;
         assign fb = st[k][CRC_W-1] ^ data_i[k];
         assign st[k+1] = {st[k][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   endgenerate
   assign crc_o = st[8];
endmodule

// File: rtl/rxf_byte_seq.sv
module rxf_byte_seq
   import rxf_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   localparam int unsigned ADDR_W = 8 * ADDR_BYTES,
   localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic              byte_vld_i,
   input  logic [7:0]        byte_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CRC_W-1:0]  crc_o,
   output logic              fin_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);
   localparam logic [CNT_W-1:0] IDLE = CNT_W'(ADDR_BYTES);

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CRC_W-1:0]  crc_q, crc_base, crc_nxt;
   logic              fin_q, take;

   assign take     = byte_vld_i & (sof_i | (cnt_q != IDLE));
   assign crc_base = sof_i ? CRC_SEED : crc_q;

   rxf_crc_step #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_step (
      .crc_i (crc_base),
      .data_i(byte_i),
      .crc_o (crc_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= IDLE;
         addr_q <= '0;
         crc_q  <= CRC_SEED;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (take) begin
            addr_q <= {addr_q[ADDR_W-9:0], byte_i};
            crc_q  <= crc_nxt;
            if (sof_i) begin
               cnt_q <= CNT_W'(1);
               fin_q <= (ADDR_BYTES == 1);
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
               fin_q <= (cnt_q == LAST);
            end
         end
      end
   end

   assign addr_o = addr_q;
   assign crc_o  = crc_q;
   assign fin_o  = fin_q;

   assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= IDLE);
   assert_fin_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |-> $past(byte_vld_i));
endmodule

// File: rtl/rxf_match.sv
module rxf_match
   import rxf_pkg::*;
#(
   parameter int unsigned ADDR_W = 48,
   parameter int unsigned HASH_WORD_W = 32,
   localparam int unsigned IDX_W = $clog2(HASH_WORD_W) + 1
) (
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [CRC_W-1:0]       crc_i,
   input  logic [ADDR_W-1:0]      station_i,
   input  logic [HASH_WORD_W-1:0] hash0_i,
   input  logic [HASH_WORD_W-1:0] hash1_i,
   input  logic                   promisc_i,
   input  logic                   bcast_rej_i,
   output logic                   hit_o
);
   logic [IDX_W-1:0] idx;
   logic is_bcast, is_group, hash_hit;

   assign idx      = crc_i[CRC_W-1 -: IDX_W];
   assign is_bcast = &addr_i;
   assign is_group = addr_i[ADDR_W-8];
   assign hash_hit = idx[IDX_W-1] ? hash1_i[idx[IDX_W-2:0]] : hash0_i[idx[IDX_W-2:0]];

   always_comb begin
      if (promisc_i)      hit_o = 1'b1;
      else if (is_bcast)  hit_o = ~bcast_rej_i;
      else if (is_group)  hit_o = hash_hit;
      else                hit_o = (addr_i == station_i);
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned HASH_WORD_W = 32,
   localparam int unsigned ADDR_W = 8 * ADDR_BYTES,
   localparam int unsigned HI_W = ADDR_W - 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sof_i,
   input  logic                   byte_vld_i,
   input  logic [7:0]             byte_i,
   input  logic [31:0]            station_lo_i,
   input  logic [HI_W-1:0]        station_hi_i,
   input  logic [HASH_WORD_W-1:0] hash0_i,
   input  logic [HASH_WORD_W-1:0] hash1_i,
   input  logic                   promisc_i,
   input  logic                   bcast_rej_i,
   output logic                   dec_vld_o,
   output logic                   accept_o
);
   initial begin
      assert (ADDR_BYTES > 4) else $error("ADDR_BYTES must exceed 4");
      assert ($clog2(HASH_WORD_W) + 1 <= CRC_W) else $error("hash index wider than CRC");
      assert (HASH_WORD_W == 2 ** $clog2(HASH_WORD_W)) else $error("HASH_WORD_W not a power of two");
   end

   logic [ADDR_W-1:0] addr, station;
   logic [CRC_W-1:0]  crc;
   logic              fin, hit;

   assign station = {station_hi_i, station_lo_i};

   rxf_byte_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof_i     (sof_i),
      .byte_vld_i(byte_vld_i),
      .byte_i    (byte_i),
      .addr_o    (addr),
      .crc_o     (crc),
      .fin_o     (fin)
   );

   rxf_match #(.ADDR_W(ADDR_W), .HASH_WORD_W(HASH_WORD_W)) u_match (
      .addr_i     (addr),
      .crc_i      (crc),
      .station_i  (station),
      .hash0_i    (hash0_i),
      .hash1_i    (hash1_i),
      .promisc_i  (promisc_i),
      .bcast_rej_i(bcast_rej_i),
      .hit_o      (hit)
   );

   assign dec_vld_o = fin;
   assign accept_o  = fin & hit;

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld_o |=> !dec_vld_o);
   assert_promisc_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld_o && promisc_i |-> accept_o);
   assert_bcast_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld_o && !promisc_i && bcast_rej_i && (&addr) |-> !accept_o);
   assert_ucast_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld_o && !addr[ADDR_W-8] && (addr == station) |-> accept_o);
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sof = 1'b0, vld = 1'b0;
   logic [7:0] bt = '0;
   logic [7:0] stn [6];
   logic [31:0] h0 = '0, h1 = '0;
   logic promisc = 1'b0, brej = 1'b0;
   logic dec_vld, accept;

   int total = 0, bad = 0, cyc = 0;
   string cur_req = "R2";

   always #5 clk = ~clk;

   rx_addr_filter u_rx_addr_filter (
      .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(vld), .byte_i(bt),
      .station_lo_i({stn[2], stn[3], stn[4], stn[5]}),
      .station_hi_i({stn[0], stn[1]}),
      .hash0_i(h0), .hash1_i(h1), .promisc_i(promisc), .bcast_rej_i(brej),
      .dec_vld_o(dec_vld), .accept_o(accept)
   );

   // behavioural reference model
   logic [7:0] m_b [6];
   int m_cnt = 6;
   bit m_vld = 0;

   function automatic logic [31:0] ref_crc(input logic [7:0] b [6]);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 8; j++) begin
            bit fb = c[31] ^ b[i][j];
            c = c << 1;
            if (fb) c = c ^ 32'h04C11DB7;
         end
      return c;
   endfunction

   function automatic bit ref_accept(input logic [7:0] b [6]);
      bit all1 = 1, same = 1;
      int idx;
      for (int i = 0; i < 6; i++) begin
         if (b[i] != 8'hFF) all1 = 0;
         if (b[i] != stn[i]) same = 0;
      end
      if (promisc) return 1;
      if (all1) return !brej;
      if (b[0][0]) begin
         idx = int'(ref_crc(b) >> 26);
         return (idx >= 32) ? h1[idx-32] : h0[idx];
      end
      return same;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 6; m_vld = 0;
      end else begin
         m_vld = 0;
         if (vld && (sof || m_cnt < 6)) begin
            if (sof) m_cnt = 0;
            m_b[m_cnt] = bt;
            m_cnt++;
            if (m_cnt == 6) m_vld = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit ea;
         string rq;
         ea = m_vld ? ref_accept(m_b) : 1'b0;
         rq = m_vld ? cur_req : "R2";
         total++;
         if (dec_vld !== m_vld || accept !== ea) begin
            bad++;
            $display("FAIL %s: vld/acc actual=%b/%b expected=%b/%b", rq, dec_vld, accept, m_vld, ea);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic send(input logic [47:0] a, input int gap, input int extra, input string rq);
      cur_req = rq;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         sof = (k == 0); vld = 1; bt = a[47-8*k -: 8];
         for (int g = 0; g < gap; g++) begin
            @(negedge clk); sof = 0; vld = 0;
         end
      end
      for (int e = 0; e < extra; e++) begin
         @(negedge clk); sof = 0; vld = 1; bt = 8'(e * 37 + 5);
      end
      @(negedge clk); sof = 0; vld = 0;
      repeat (3) @(negedge clk);
   endtask

   function automatic int idx_of(input logic [47:0] a);
      logic [7:0] b [6];
      for (int i = 0; i < 6; i++) b[i] = a[47-8*i -: 8];
      return int'(ref_crc(b) >> 26);
   endfunction

   task automatic set_bit(input int idx, input bit v);
      if (idx >= 32) h1[idx-32] = v; else h0[idx] = v;
   endtask

   initial begin
      logic [47:0] ma0, ma1;
      bit f0, f1;
      stn[0] = 8'h02; stn[1] = 8'h1A; stn[2] = 8'h3C;
      stn[3] = 8'h55; stn[4] = 8'h9E; stn[5] = 8'hC7;
      repeat (3) @(negedge clk);
      total++;
      if (dec_vld !== 1'b0 || accept !== 1'b0) begin
         bad++; $display("FAIL R1: reset outputs actual=%b%b expected=00", dec_vld, accept);
      end
      rst_n = 1;
      // R1: bytes without start marker
      cur_req = "R1";
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); vld = 1; sof = 0; bt = stn[i % 6];
      end
      @(negedge clk); vld = 0;
      repeat (3) @(negedge clk);
      // R3 exact unicast match
      send({stn[0], stn[1], stn[2], stn[3], stn[4], stn[5]}, 0, 0, "R3");
      // R11 gapped
      send({stn[0], stn[1], stn[2], stn[3], stn[4], stn[5]}, 2, 0, "R11");
      // R4 mismatches
      send({8'h06, stn[1], stn[2], stn[3], stn[4], stn[5]}, 0, 0, "R4");
      send({stn[0], stn[1], stn[2], stn[3], stn[4], 8'hC6}, 0, 0, "R4");
      send({stn[0], stn[1], 8'h3D, stn[3], stn[4], stn[5]}, 1, 0, "R4");
      // R5 / R6 broadcast
      brej = 0; send(48'hFFFF_FFFF_FFFF, 0, 0, "R5");
      brej = 1; send(48'hFFFF_FFFF_FFFF, 0, 0, "R6");
      // R7 promiscuous
      promisc = 1;
      send(48'hFFFF_FFFF_FFFF, 0, 0, "R7");
      send(48'h0012_3456_789A, 0, 0, "R7");
      send(48'h0133_0000_0001, 0, 0, "R7");
      promisc = 0; brej = 0;
      // R8 hash: find multicast addresses hitting each hash word
      f0 = 0; f1 = 0; ma0 = '0; ma1 = '0;
      for (int k = 0; k < 200 && !(f0 && f1); k++) begin
         logic [47:0] a = {8'h01, 8'h00, 8'h5E, 8'h00, 8'(k >> 8), 8'(k)};
         if (!f0 && idx_of(a) < 32) begin ma0 = a; f0 = 1; end
         if (!f1 && idx_of(a) >= 32) begin ma1 = a; f1 = 1; end
      end
      h0 = '0; h1 = '0;
      set_bit(idx_of(ma0), 1); send(ma0, 0, 0, "R8");
      h0 = '1; h1 = '1;
      set_bit(idx_of(ma0), 0); send(ma0, 0, 0, "R8");
      h0 = '0; h1 = '0;
      set_bit(idx_of(ma1), 1); send(ma1, 0, 0, "R8");
      send(ma0, 0, 0, "R8");
      h0 = '1; h1 = '1;
      set_bit(idx_of(ma1), 0); send(ma1, 0, 0, "R8");
      // R9 all-ones / all-zero table
      h0 = '1; h1 = '1;
      send(48'h0100_5E7F_0001, 0, 0, "R9");
      send(48'h3333_0000_00FB, 0, 0, "R9");
      h0 = '0; h1 = '0;
      send(48'h0100_5E7F_0001, 0, 0, "R9");
      send(48'h3333_0000_00FB, 0, 0, "R9");
      // R10 trailing bytes ignored, restart mid-address
      send({stn[0], stn[1], stn[2], stn[3], stn[4], stn[5]}, 0, 9, "R10");
      cur_req = "R10";
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); sof = (i == 0); vld = 1; bt = 8'hAA;
      end
      send({stn[0], stn[1], stn[2], stn[3], stn[4], stn[5]}, 0, 0, "R10");
      repeat (5) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule